// File: doc/BRIEF.md
# Pipelined Fused-Pair Issue Scheduler

This block is the out-of-order issue queue of a core whose scheduler is cut into two pipe stages: a slot is granted at one clock edge, and the destination tag of what it issued reaches the wakeup comparators in a later cycle. Every queue slot holds either a single micro-op or a fused dependent pair: a single-cycle ALU head and a tail that consumes the head's result directly. One grant sends both halves of a pair down the same issue lane in the same cycle.

Dispatch writes one entry per cycle. An entry carries up to three external source tags, each with a valid and a ready flag, plus a head destination tag, a tail destination tag, a fused flag and a long-latency flag. Tag broadcasts come out on fixed ports, three per issue lane: a head port one cycle after issue, a tail port two cycles after issue, and a long-latency port `LONG_LAT-1` cycles after issue. The scheduler watches its own broadcast ports to wake waiting sources. Each cycle the oldest ready slots are granted, up to `ISSUE_W` of them. A flush empties the queue and cancels everything in flight.

Top module: `fused_pair_sched`

## Requirements
- R1: After reset, `disp_ready` is 1, and `iss_vld` and `bc_vld` are all zero.
- R2: A slot issues only once every source whose valid bit is set is ready. For a fused slot this includes the tail's sources, so one late source holds back the whole pair until its tag is broadcast.
- R3: A non-fused short-latency op issued in cycle c broadcasts its head destination tag on port 3·lane in cycle c+1. A consumer waiting only on that tag issues in cycle c+2.
- R4: A non-fused long op (`disp_long`=1) issued in cycle c broadcasts on port 3·lane+2 in cycle c+LONG_LAT-1, and nothing on the other ports of that lane. A consumer waiting on it issues in cycle c+LONG_LAT.
- R5: A fused slot issues both halves on one lane in one cycle, with `iss_fused`=1 and both destination tags. The head tag goes out on port 3·lane in c+1 and the tail tag on port 3·lane+1 in c+2. `disp_long` has no effect on a fused entry.
- R6: Among ready slots, the oldest by dispatch order goes to lane 0, the next to lane 1, and so on up to `ISSUE_W` per cycle. Slot index does not affect the order.
- R7: A dispatched entry can first issue two cycles after the cycle in which it was offered. `disp_ready` is 0 exactly when all `DEPTH` slots are occupied, and an entry offered while it is 0 is dropped. A slot granted at an edge is free in the cycle its op appears on the issue outputs.
- R8: `flush` empties every slot in one cycle and cancels pending issues and broadcasts. In the next cycle `disp_ready` is 1, and the issue and broadcast outputs are zero. An entry offered during the flush cycle is dropped.
- R9: A source whose tag is on any broadcast port in the cycle it is dispatched is recorded as ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty the queue and cancel in-flight issues and broadcasts |
| disp_valid | input | 1 | Dispatch offers an entry |
| disp_ready | output | 1 | A free slot exists |
| disp_fused | input | 1 | Entry is a fused head+tail pair |
| disp_long | input | 1 | Non-fused entry has long latency |
| disp_src_vld | input | NSRC | Source tag in use |
| disp_src_tag | input | NSRC*TAG_W | Source tags, source s at bits [s*TAG_W +: TAG_W] |
| disp_src_rdy | input | NSRC | Source already available at dispatch |
| disp_head_dst | input | TAG_W | Head (or single op) destination tag |
| disp_tail_dst | input | TAG_W | Tail destination tag |
| iss_vld | output | ISSUE_W | Lane issues a slot this cycle |
| iss_fused | output | ISSUE_W | Issued slot is a fused pair |
| iss_head_dst | output | ISSUE_W*TAG_W | Head destination tag per lane |
| iss_tail_dst | output | ISSUE_W*TAG_W | Tail destination tag per lane |
| bc_vld | output | 3*ISSUE_W | Broadcast valid, port 3·lane+{0 head,1 tail,2 long} |
| bc_tag | output | 3*ISSUE_W*TAG_W | Broadcast tag per port |

## Verification
The hardest case to reach is an age order that differs from slot order, with several slots woken by the same broadcast. The stimulus gets there by letting a ready entry in slot 0 issue first. This frees the lowest slot for a younger entry while an older one waits in slot 1. A single producer then wakes three waiting entries at once, and the lane assignment shows whether age or index decided it. Another hard case is a fused pair held back only by its tail's source, which is released by a producer dispatched later.

// File: rtl/fps_pkg.sv
// Shared definitions for the fused-pair scheduler.
// Assumes long-latency ops take at least two cycles.
package fps_pkg;

    localparam int PORTS_PER_LANE = 3;

    // Broadcast port kinds within one issue lane.
    typedef enum logic [1:0] {
        BC_HEAD = 2'd0,
        BC_TAIL = 2'd1,
        BC_LONG = 2'd2
    } bc_kind_e;

    // Cycles from the issue register to the broadcast of each port kind.
    function automatic int bc_delay(input bc_kind_e kind, input int long_lat);
        case (kind)
            BC_HEAD: return 1;
            BC_TAIL: return 2;
            default: return long_lat - 1;
        endcase
    endfunction

endpackage

// File: rtl/fps_bcast_delay.sv
// Fixed-delay valid/tag pipeline feeding one broadcast port.
// Assumes DELAY >= 1. A flush cancels every stage at once.
module fps_bcast_delay #(
    parameter int TAG_W = 6,
    parameter int DELAY = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             in_vld,
    input  logic [TAG_W-1:0] in_tag,
    output logic             out_vld,
    output logic [TAG_W-1:0] out_tag
);

    logic [DELAY-1:0] vld_sr;
    logic [TAG_W-1:0] tag_sr [DELAY];

    for (genvar g = 0; g < DELAY; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage captures the issue-register value.
            always_ff @(posedge clk) begin
                if (!rst_n || flush) vld_sr[g] <= 1'b0;
                else                 vld_sr[g] <= in_vld;
                tag_sr[g] <= in_tag;
            end
        end else begin : g_next
            // Later stages shift the previous stage along.
            always_ff @(posedge clk) begin
                if (!rst_n || flush) vld_sr[g] <= 1'b0;
                else                 vld_sr[g] <= vld_sr[g-1];
                tag_sr[g] <= tag_sr[g-1];
            end
        end
    end

    assign out_vld = vld_sr[DELAY-1];
    assign out_tag = tag_sr[DELAY-1];

endmodule

// File: rtl/fps_select.sv
// Oldest-first select over the queue slots, using an age matrix.
// older[j][i] = 1 means slot j was dispatched before slot i. A slot's rank
// is the number of older requesting slots, and rank r is granted lane r.
// Assumes DEPTH >= 2 and at most one allocation per cycle.
module fps_select #(
    parameter int DEPTH   = 4,
    parameter int ISSUE_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       alloc_vld,
    input  logic [$clog2(DEPTH)-1:0]   alloc_idx,
    input  logic [DEPTH-1:0]           req,
    output logic [ISSUE_W*DEPTH-1:0]   gnt,
    output logic [DEPTH-1:0]           gnt_any
);

    localparam int RW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] older [DEPTH];
    logic [RW-1:0]    rank  [DEPTH];
    logic [ISSUE_W-1:0] lane_busy;

    // The newly allocated slot becomes younger than every other slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++) older[j] <= '0;
        end else if (alloc_vld) begin
            for (int j = 0; j < DEPTH; j++) begin
                if (j != int'(alloc_idx)) begin
                    older[j][alloc_idx] <= 1'b1;
                    older[alloc_idx][j] <= 1'b0;
                end
            end
        end
    end

    // Count the older requesters of each slot.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            rank[i] = '0;
            for (int j = 0; j < DEPTH; j++) begin
                if (j != i && req[j] && older[j][i]) rank[i] = rank[i] + 1'b1;
            end
        end
    end

    // Map rank to lane and mark each granted slot.
    always_comb begin
        for (int r = 0; r < ISSUE_W; r++) begin
            for (int i = 0; i < DEPTH; i++) begin
                gnt[r*DEPTH+i] = req[i] && (int'(rank[i]) == r);
            end
            lane_busy[r] = |gnt[r*DEPTH +: DEPTH];
        end
        for (int i = 0; i < DEPTH; i++) begin
            gnt_any[i] = req[i] && (int'(rank[i]) < ISSUE_W);
        end
    end

    for (genvar r = 0; r < ISSUE_W; r++) begin : g_chk
        AST_LANE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gnt[r*DEPTH +: DEPTH])); // R6
    end

    AST_OLDEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (|(req & ~gnt_any)) |-> (&lane_busy)); // R6

endmodule

// File: rtl/fused_pair_sched.sv
// Issue queue with select and wakeup in separate pipe stages.
// Each slot holds a single op or a fused head+tail pair. Grants go to the
// oldest ready slots. Tags come back on fixed-delay broadcast ports and
// wake waiting sources in the cycle they are visible.
// Assumes: one dispatch per cycle; a fused head is a single-cycle ALU op
// and its tail is single-cycle; LONG_LAT >= 2; DEPTH >= 2.
module fused_pair_sched #(
    parameter int DEPTH    = 4,
    parameter int ISSUE_W  = 2,
    parameter int TAG_W    = 6,
    parameter int NSRC     = 3,
    parameter int LONG_LAT = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic                          disp_valid,
    output logic                          disp_ready,
    input  logic                          disp_fused,
    input  logic                          disp_long,
    input  logic [NSRC-1:0]               disp_src_vld,
    input  logic [NSRC*TAG_W-1:0]         disp_src_tag,
    input  logic [NSRC-1:0]               disp_src_rdy,
    input  logic [TAG_W-1:0]              disp_head_dst,
    input  logic [TAG_W-1:0]              disp_tail_dst,
    output logic [ISSUE_W-1:0]            iss_vld,
    output logic [ISSUE_W-1:0]            iss_fused,
    output logic [ISSUE_W*TAG_W-1:0]      iss_head_dst,
    output logic [ISSUE_W*TAG_W-1:0]      iss_tail_dst,
    output logic [3*ISSUE_W-1:0]          bc_vld,
    output logic [3*ISSUE_W*TAG_W-1:0]    bc_tag
);

    import fps_pkg::*;

    localparam int IDX_W = $clog2(DEPTH);
    localparam int NPORT = PORTS_PER_LANE * ISSUE_W;

    // Slot storage.
    logic [DEPTH-1:0] q_vld;
    logic [DEPTH-1:0] q_fused;
    logic [DEPTH-1:0] q_long;
    logic [NSRC-1:0]  q_sv [DEPTH];
    logic [NSRC-1:0]  q_sr [DEPTH];
    logic [TAG_W-1:0] q_st [DEPTH][NSRC];
    logic [TAG_W-1:0] q_hd [DEPTH];
    logic [TAG_W-1:0] q_td [DEPTH];

    logic [NSRC-1:0]  src_hit [DEPTH];
    logic [NSRC-1:0]  disp_hit;
    logic [DEPTH-1:0] slot_ready;
    logic [IDX_W-1:0] wr_idx;
    logic             disp_fire;
    logic [ISSUE_W*DEPTH-1:0] gnt;
    logic [DEPTH-1:0] gnt_any;
    logic [ISSUE_W-1:0] iss_long;

    logic [ISSUE_W-1:0] sel_vld, sel_fused, sel_long;
    logic [TAG_W-1:0]   sel_hd [ISSUE_W];
    logic [TAG_W-1:0]   sel_td [ISSUE_W];

    assign disp_ready = ~&q_vld;
    assign disp_fire  = disp_valid && disp_ready && !flush;

    // Lowest free slot receives the next dispatch.
    always_comb begin
        wr_idx = '0;
        for (int d = DEPTH - 1; d >= 0; d--) begin
            if (!q_vld[d]) wr_idx = IDX_W'(d);
        end
    end

    // Wakeup stage: compare stored and incoming source tags with every broadcast port.
    always_comb begin
        for (int d = 0; d < DEPTH; d++) begin
            for (int s = 0; s < NSRC; s++) begin
                src_hit[d][s] = 1'b0;
                for (int p = 0; p < NPORT; p++) begin
                    if (bc_vld[p] && bc_tag[p*TAG_W +: TAG_W] == q_st[d][s]) src_hit[d][s] = 1'b1;
                end
            end
        end
        for (int s = 0; s < NSRC; s++) begin
            disp_hit[s] = 1'b0;
            for (int p = 0; p < NPORT; p++) begin
                if (bc_vld[p] && bc_tag[p*TAG_W +: TAG_W] == disp_src_tag[s*TAG_W +: TAG_W])
                    disp_hit[s] = 1'b1;
            end
        end
    end

    // A slot is ready when each used source is recorded ready or is hit now.
    always_comb begin
        for (int d = 0; d < DEPTH; d++) begin
            slot_ready[d] = q_vld[d];
            for (int s = 0; s < NSRC; s++) begin
                if (q_sv[d][s] && !q_sr[d][s] && !src_hit[d][s]) slot_ready[d] = 1'b0;
            end
        end
    end

    // Slot occupancy: set on dispatch, cleared on grant or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            q_vld <= '0;
        end else begin
            for (int d = 0; d < DEPTH; d++) begin
                if (gnt_any[d]) q_vld[d] <= 1'b0;
                if (disp_fire && int'(wr_idx) == d) q_vld[d] <= 1'b1;
            end
        end
    end

    // Slot payload: written on dispatch; ready flags accumulate wakeups.
    always_ff @(posedge clk) begin
        for (int d = 0; d < DEPTH; d++) begin
            q_sr[d] <= q_sr[d] | src_hit[d];
            if (disp_fire && int'(wr_idx) == d) begin
                q_fused[d] <= disp_fused;
                q_long[d]  <= disp_long && !disp_fused;
                q_sv[d]    <= disp_src_vld;
                q_sr[d]    <= disp_src_rdy | disp_hit;
                q_hd[d]    <= disp_head_dst;
                q_td[d]    <= disp_tail_dst;
                for (int s = 0; s < NSRC; s++) q_st[d][s] <= disp_src_tag[s*TAG_W +: TAG_W];
            end
        end
    end

    fps_select #(
        .DEPTH   (DEPTH),
        .ISSUE_W (ISSUE_W)
    ) u_select (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_vld (disp_fire),
        .alloc_idx (wr_idx),
        .req       (slot_ready),
        .gnt       (gnt),
        .gnt_any   (gnt_any)
    );

    // Per-lane mux from the granted slot into the issue register.
    always_comb begin
        for (int r = 0; r < ISSUE_W; r++) begin
            sel_vld[r]   = 1'b0;
            sel_fused[r] = 1'b0;
            sel_long[r]  = 1'b0;
            sel_hd[r]    = '0;
            sel_td[r]    = '0;
            for (int d = 0; d < DEPTH; d++) begin
                if (gnt[r*DEPTH+d]) begin
                    sel_vld[r]   = 1'b1;
                    sel_fused[r] = q_fused[d];
                    sel_long[r]  = q_long[d];
                    sel_hd[r]    = q_hd[d];
                    sel_td[r]    = q_td[d];
                end
            end
        end
    end

    // Issue register: the select stage's output.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            iss_vld      <= '0;
            iss_fused    <= '0;
            iss_long     <= '0;
            iss_head_dst <= '0;
            iss_tail_dst <= '0;
        end else begin
            iss_vld   <= sel_vld;
            iss_fused <= sel_fused;
            iss_long  <= sel_long;
            for (int r = 0; r < ISSUE_W; r++) begin
                iss_head_dst[r*TAG_W +: TAG_W] <= sel_hd[r];
                iss_tail_dst[r*TAG_W +: TAG_W] <= sel_td[r];
            end
        end
    end

    for (genvar ln = 0; ln < ISSUE_W; ln++) begin : g_lane
        for (genvar k = 0; k < PORTS_PER_LANE; k++) begin : g_port
            localparam int DLY = bc_delay(bc_kind_e'(k), LONG_LAT);
            logic             pv;
            logic [TAG_W-1:0] pt;
            if (k == int'(BC_HEAD)) begin : g_head
                assign pv = iss_vld[ln] && (iss_fused[ln] || !iss_long[ln]);
                assign pt = iss_head_dst[ln*TAG_W +: TAG_W];
            end else if (k == int'(BC_TAIL)) begin : g_tail
                assign pv = iss_vld[ln] && iss_fused[ln];
                assign pt = iss_tail_dst[ln*TAG_W +: TAG_W];
            end else begin : g_long
                assign pv = iss_vld[ln] && iss_long[ln] && !iss_fused[ln];
                assign pt = iss_head_dst[ln*TAG_W +: TAG_W];
            end
            fps_bcast_delay #(
                .TAG_W (TAG_W),
                .DELAY (DLY)
            ) u_delay (
                .clk     (clk),
                .rst_n   (rst_n),
                .flush   (flush),
                .in_vld  (pv),
                .in_tag  (pt),
                .out_vld (bc_vld[ln*PORTS_PER_LANE+k]),
                .out_tag (bc_tag[(ln*PORTS_PER_LANE+k)*TAG_W +: TAG_W])
            );
        end

        AST_HEAD_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_vld[ln] && (iss_fused[ln] || !iss_long[ln]) && !flush) |=>
            (bc_vld[ln*3] && bc_tag[ln*3*TAG_W +: TAG_W] == $past(iss_head_dst[ln*TAG_W +: TAG_W]))); // R3
        AST_TAIL_AFTER_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
            bc_vld[ln*3+1] |-> $past(bc_vld[ln*3])); // R5
    end

    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (iss_vld == '0 && bc_vld == '0 && disp_ready)); // R8
    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        disp_fire |-> !q_vld[wr_idx]); // R7

endmodule

// File: tb/fused_pair_sched_bench.sv
module fused_pair_sched_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LONG_LAT   = 3;
    localparam int TW         = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        disp_valid = 1'b0;
    logic        disp_ready;
    logic        disp_fused = 1'b0;
    logic        disp_long = 1'b0;
    logic [2:0]  disp_src_vld = '0;
    logic [17:0] disp_src_tag = '0;
    logic [2:0]  disp_src_rdy = '0;
    logic [5:0]  disp_head_dst = '0;
    logic [5:0]  disp_tail_dst = '0;
    logic [1:0]  iss_vld, iss_fused;
    logic [11:0] iss_head_dst, iss_tail_dst;
    logic [5:0]  bc_vld;
    logic [35:0] bc_tag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    fused_pair_sched #(.LONG_LAT(LONG_LAT)) u_fused_pair_sched (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .disp_valid(disp_valid), .disp_ready(disp_ready),
        .disp_fused(disp_fused), .disp_long(disp_long),
        .disp_src_vld(disp_src_vld), .disp_src_tag(disp_src_tag),
        .disp_src_rdy(disp_src_rdy), .disp_head_dst(disp_head_dst),
        .disp_tail_dst(disp_tail_dst),
        .iss_vld(iss_vld), .iss_fused(iss_fused),
        .iss_head_dst(iss_head_dst), .iss_tail_dst(iss_tail_dst),
        .bc_vld(bc_vld), .bc_tag(bc_tag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic       fused;
        logic       lng;
        logic [5:0] hd;
        logic [5:0] td;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{1'b0, 1'b0, 6'd1, 6'd0},
        '{1'b0, 1'b1, 6'd2, 6'd0},
        '{1'b1, 1'b0, 6'd3, 6'd4},
        '{1'b1, 1'b1, 6'd5, 6'd6}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic disp(input logic f, input logic l, input logic [2:0] sv,
                        input logic [17:0] st, input logic [2:0] sr,
                        input logic [5:0] hd, input logic [5:0] td);
        disp_valid    = 1'b1;
        disp_fused    = f;
        disp_long     = l;
        disp_src_vld  = sv;
        disp_src_tag  = st;
        disp_src_rdy  = sr;
        disp_head_dst = hd;
        disp_tail_dst = td;
        step();
        disp_valid = 1'b0;
    endtask

    task automatic drain();
        for (int k = 0; k < 4; k++) step();
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1", "disp_ready", int'(disp_ready), 1);
        chk("R1", "iss_vld", int'(iss_vld), 0);
        chk("R1", "bc_vld", int'(bc_vld), 0);

        // Table walk: one independent entry per vector (R3, R4, R5, R7).
        for (int v = 0; v < 4; v++) begin
            disp(VECS[v].fused, VECS[v].lng, 3'b011, {6'd0, 6'd51, 6'd50}, 3'b011,
                 VECS[v].hd, VECS[v].td);
            chk("R7", "iss_vld in dispatch+1", int'(iss_vld), 0);
            step();
            chk("R7", "iss_vld at dispatch+2", int'(iss_vld), 1);
            chk("R5", "iss_fused", int'(iss_fused[0]), int'(VECS[v].fused));
            chk("R3", "iss head", int'(iss_head_dst[5:0]), int'(VECS[v].hd));
            if (VECS[v].fused) chk("R5", "iss tail", int'(iss_tail_dst[5:0]), int'(VECS[v].td));
            for (int k = 1; k <= LONG_LAT; k++) begin
                logic [5:0] e;
                step();
                e = '0;
                if (k == 1 && (VECS[v].fused || !VECS[v].lng)) e[0] = 1'b1;
                if (k == 2 && VECS[v].fused) e[1] = 1'b1;
                if (k == LONG_LAT - 1 && !VECS[v].fused && VECS[v].lng) e[2] = 1'b1;
                chk("R3/R4/R5", $sformatf("bc_vld v%0d k%0d", v, k), int'(bc_vld), int'(e));
                if (e[0]) chk("R3", "head port tag", int'(bc_tag[5:0]), int'(VECS[v].hd));
                if (e[1]) chk("R5", "tail port tag", int'(bc_tag[11:6]), int'(VECS[v].td));
                if (e[2]) chk("R4", "long port tag", int'(bc_tag[17:12]), int'(VECS[v].hd));
            end
        end

        // R3 single-cycle producer -> consumer two cycles later
        disp(1'b0, 1'b0, 3'b000, '0, 3'b000, 6'd7, 6'd0);
        disp(1'b0, 1'b0, 3'b001, {12'd0, 6'd7}, 3'b000, 6'd8, 6'd0);
        chk("R3", "producer issued", int'(iss_head_dst[5:0]), 7);
        step();
        chk("R3", "no issue one cycle after producer", int'(iss_vld), 0);
        step();
        chk("R3", "consumer issued", int'(iss_vld), 1);
        chk("R3", "consumer tag", int'(iss_head_dst[5:0]), 8);
        drain();

        // R4 long producer -> consumer LONG_LAT cycles later
        disp(1'b0, 1'b1, 3'b000, '0, 3'b000, 6'd9, 6'd0);
        disp(1'b0, 1'b0, 3'b001, {12'd0, 6'd9}, 3'b000, 6'd10, 6'd0);
        chk("R4", "long producer issued", int'(iss_head_dst[5:0]), 9);
        for (int k = 1; k < LONG_LAT; k++) begin
            step();
            chk("R4", "consumer still waiting", int'(iss_vld), 0);
        end
        step();
        chk("R4", "consumer issued", int'(iss_vld), 1);
        chk("R4", "consumer tag", int'(iss_head_dst[5:0]), 10);
        drain();

        // R9 dispatch in the same cycle as the producer broadcast
        disp(1'b0, 1'b0, 3'b000, '0, 3'b000, 6'd21, 6'd0);
        step();
        step();
        chk("R9", "broadcast visible", int'(bc_vld[0]), 1);
        disp(1'b0, 1'b0, 3'b001, {12'd0, 6'd21}, 3'b000, 6'd22, 6'd0);
        step();
        chk("R9", "consumer issued", int'(iss_vld), 1);
        chk("R9", "consumer tag", int'(iss_head_dst[5:0]), 22);
        drain();

        // R2 fused pair held back by its tail source
        disp(1'b1, 1'b0, 3'b101, {6'd15, 6'd0, 6'd50}, 3'b001, 6'd23, 6'd24);
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R2", "pair waits for tail source", int'(iss_vld), 0);
        end
        disp(1'b0, 1'b0, 3'b000, '0, 3'b000, 6'd15, 6'd0);
        step();
        chk("R2", "only producer issued", int'(iss_vld), 1);
        chk("R2", "producer tag", int'(iss_head_dst[5:0]), 15);
        step();
        step();
        chk("R2", "pair issued", int'(iss_vld), 1);
        chk("R2", "pair fused", int'(iss_fused[0]), 1);
        chk("R2", "pair head", int'(iss_head_dst[5:0]), 23);
        chk("R2", "pair tail", int'(iss_tail_dst[5:0]), 24);
        drain();

        // R6 oldest-first with age order differing from slot order
        disp(1'b0, 1'b0, 3'b000, '0, 3'b000, 6'd25, 6'd0);
        disp(1'b0, 1'b0, 3'b001, {12'd0, 6'd33}, 3'b000, 6'd11, 6'd0);
        disp(1'b0, 1'b0, 3'b001, {12'd0, 6'd33}, 3'b000, 6'd12, 6'd0);
        disp(1'b0, 1'b0, 3'b001, {12'd0, 6'd33}, 3'b000, 6'd13, 6'd0);
        disp(1'b0, 1'b0, 3'b000, '0, 3'b000, 6'd33, 6'd0);
        step();
        chk("R6", "producer issued", int'(iss_head_dst[5:0]), 33);
        step();
        chk("R6", "waiting during broadcast", int'(iss_vld), 0);
        step();
        chk("R6", "two lanes busy", int'(iss_vld), 3);
        chk("R6", "lane0 oldest", int'(iss_head_dst[5:0]), 11);
        chk("R6", "lane1 next", int'(iss_head_dst[11:6]), 12);
        step();
        chk("R6", "remaining one", int'(iss_vld), 1);
        chk("R6", "youngest last", int'(iss_head_dst[5:0]), 13);
        drain();

        // R7 full queue, freed slot, dropped dispatch
        disp(1'b0, 1'b0, 3'b001, {12'd0, 6'd40}, 3'b000, 6'd41, 6'd0);
        disp(1'b0, 1'b0, 3'b001, {12'd0, 6'd40}, 3'b000, 6'd42, 6'd0);
        disp(1'b0, 1'b0, 3'b001, {12'd0, 6'd40}, 3'b000, 6'd43, 6'd0);
        chk("R7", "ready with one free slot", int'(disp_ready), 1);
        disp(1'b0, 1'b0, 3'b000, '0, 3'b000, 6'd44, 6'd0);
        chk("R7", "full queue not ready", int'(disp_ready), 0);
        step();
        chk("R7", "ready entry issued", int'(iss_head_dst[5:0]), 44);
        chk("R7", "freed slot available", int'(disp_ready), 1);
        disp(1'b0, 1'b0, 3'b001, {12'd0, 6'd40}, 3'b000, 6'd45, 6'd0);
        chk("R7", "full again", int'(disp_ready), 0);
        disp(1'b0, 1'b0, 3'b000, '0, 3'b000, 6'd46, 6'd0);
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R7", "dropped entry never issues", int'(iss_vld), 0);
        end

        // R8 flush empties the queue and drops a same-cycle dispatch
        flush = 1'b1;
        disp(1'b0, 1'b0, 3'b000, '0, 3'b000, 6'd47, 6'd0);
        flush = 1'b0;
        chk("R8", "disp_ready after flush", int'(disp_ready), 1);
        chk("R8", "iss_vld after flush", int'(iss_vld), 0);
        chk("R8", "bc_vld after flush", int'(bc_vld), 0);
        step();
        step();
        chk("R8", "flush-cycle dispatch dropped", int'(iss_vld), 0);
        disp(1'b0, 1'b0, 3'b000, '0, 3'b000, 6'd40, 6'd0);
        step();
        chk("R8", "wake producer issued", int'(iss_head_dst[5:0]), 40);
        step();
        step();
        chk("R8", "flushed waiters stay gone", int'(iss_vld), 0);
        drain();

        // R8 flush cancels a pending broadcast
        disp(1'b0, 1'b0, 3'b000, '0, 3'b000, 6'd48, 6'd0);
        step();
        chk("R8", "issued before flush", int'(iss_vld), 1);
        flush = 1'b1;
        step();
        flush = 1'b0;
        chk("R8", "broadcast cancelled", int'(bc_vld), 0);
        drain();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule